// File: doc/BRIEF.md
# Per-Processor Priority Acknowledge Engine

This block sits between an interrupt distributor and one processor. The distributor hands it source indices one at a time. The engine keeps two bit-sets over the sources. The pending set holds sources delivered but not yet taken. The in-service set holds sources the processor has taken and not yet finished. A programmable task priority masks the processor: a delivery at or below it is turned away. Each accepted delivery may raise the processor's interrupt line. Whether it does depends on what is already pending and on what is being serviced.

The processor works the engine through a small register port. It writes a task priority and a spurious vector. It reads an acknowledge register, which returns the vector of the best pending source, or the spurious vector when that source has gone stale. It writes an end-of-interrupt register to retire the best in-service source. The engine stores no per-source configuration. It reads priorities from a flat bus, and it reads the vector, activity and sense of one source through an indexed lookup. It tells the source storage when to set or clear a source's activity flag and when to clear its latched request.

Delivery is a valid/ready stream. `dlv_ready` is low in every cycle that carries a register read or write strobe. A delivery is taken only on a cycle where `dlv_valid` and `dlv_ready` are both high. A sender that keeps `dlv_valid` and `dlv_idx` steady will be taken on the next free cycle.

Top module: `prio_ack_engine`

## Requirements
- R1: After reset, the task priority reads back as all ones (15 for 4-bit priorities), the spurious vector reads back as 0xFF, `irq_out` is low, and both sets are empty.
- R2: A delivery whose source priority is less than or equal to the task priority is dropped. It raises no `act_set` pulse and does not change `irq_out`.
- R3: A delivery of a source that is already in the pending set is dropped, with no `act_set` pulse.
- R4: An accepted delivery pulses `act_set` with its index in the same cycle and joins the pending set. `irq_out` goes high at the next edge, except when a pending source of strictly higher priority exists or the top in-service source has strictly higher priority. In those cases `irq_out` keeps its value.
- R5: The best member of a set is the one with the highest priority. When priorities tie, the lowest source index wins.
- R6: An acknowledge read drives `irq_out` low at the next edge. With the pending set empty, it returns the spurious vector.
- R7: If the best pending source is inactive, or its priority no longer exceeds the task priority, the acknowledge returns the spurious vector and pulses `act_clr` for that source. The source leaves the pending set and does not enter the in-service set.
- R8: Otherwise the acknowledge returns the source's vector from `lk_vec`. The source moves from the pending set to the in-service set.
- R9: Acknowledging an edge-sensitive source (`lk_level` = 0) pulses both `act_clr` and `act_clr_pend` for it in the strobe cycle.
- R10: An end-of-interrupt write retires the best in-service source. `irq_out` then goes high if a pending source remains and either the in-service set is now empty or that pending priority exceeds the new best in-service priority. Otherwise `irq_out` keeps its value.
- R11: Register select codes are 0 = task priority, 1 = acknowledge, 2 = end-of-interrupt, 3 = spurious vector. Read data is valid with `rd_valid` one cycle after the `reg_rd` strobe. Reading the end-of-interrupt code returns zero.
- R12: `dlv_ready` is low whenever `reg_rd` or `reg_wr` is high. A delivery offered in such a cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery offered |
| dlv_ready | output | 1 | Delivery can be taken this cycle |
| dlv_idx | input | IW | Delivered source index |
| src_prio | input | N_SRC x PRIO_W | Priority of every source |
| lk_idx | output | IW | Source looked up (best pending source) |
| lk_vec | input | VEC_W | Vector of the looked-up source |
| lk_active | input | 1 | Activity flag of the looked-up source |
| lk_level | input | 1 | 1 = level-sensitive, 0 = edge-sensitive |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | VEC_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | VEC_W | Read data |
| act_set | output | 1 | Set activity of `act_set_idx` |
| act_set_idx | output | IW | Source whose activity is set |
| act_clr | output | 1 | Clear activity of `act_clr_idx` |
| act_clr_pend | output | 1 | Also clear the latched request of `act_clr_idx` |
| act_clr_idx | output | IW | Source whose activity is cleared |
| irq_out | output | 1 | Registered interrupt line to the processor |

## Verification
The strobes `act_set`, `act_clr` and `act_clr_pend` are combinational and are due in the same cycle as the delivery or acknowledge that causes them. `irq_out`, `rd_valid` and `rd_data` are due one edge later. The bench drives every input on the falling edge. It samples the combinational strobes 1 ns after driving them. It samples the registered results at the following falling edge, after exactly one rising edge has passed. Each scenario starts from a fresh reset, so every expected set content follows from that scenario's own steps.

// File: rtl/ack_pkg.sv
package ack_pkg;
  typedef enum logic [1:0] {
    SEL_TASK = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_SPUR = 2'd3
  } ack_sel_e;
endpackage

// File: rtl/ack_prio_pick.sv
module ack_prio_pick #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             members,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic                         any,
  output logic [IW-1:0]                idx,
  output logic [PRIO_W-1:0]            top
);
  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    any = 1'b0;
    idx = '0;
    top = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (members[i] && (!any || prio[i] > top)) begin
        any = 1'b1;
        idx = IW'(i);
        top = prio[i];
      end
    end
  end
endmodule

// File: rtl/ack_cfg_regs.sv
module ack_cfg_regs #(
  parameter int TP_W  = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tp_we,
  input  logic             spv_we,
  input  logic [VEC_W-1:0] wdata,
  output logic [TP_W-1:0]  tp,
  output logic [VEC_W-1:0] spv
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tp  <= '1;
      spv <= '1;
    end else begin
      if (tp_we)  tp  <= wdata[TP_W-1:0];
      if (spv_we) spv <= wdata;
    end
  end

  a_r1_tp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_we |=> $stable(tp));
  a_r1_spv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !spv_we |=> $stable(spv));
endmodule

// File: rtl/prio_ack_engine.sv
module prio_ack_engine
  import ack_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dlv_valid,
  output logic                         dlv_ready,
  input  logic [IW-1:0]                dlv_idx,
  input  logic [N_SRC-1:0][PRIO_W-1:0] src_prio,
  output logic [IW-1:0]                lk_idx,
  input  logic [VEC_W-1:0]             lk_vec,
  input  logic                         lk_active,
  input  logic                         lk_level,
  input  logic                         reg_rd,
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_sel,
  input  logic [VEC_W-1:0]             reg_wdata,
  output logic                         rd_valid,
  output logic [VEC_W-1:0]             rd_data,
  output logic                         act_set,
  output logic [IW-1:0]                act_set_idx,
  output logic                         act_clr,
  output logic                         act_clr_pend,
  output logic [IW-1:0]                act_clr_idx,
  output logic                         irq_out
);
  ack_sel_e sel;
  assign sel = ack_sel_e'(reg_sel);

  logic [N_SRC-1:0] pend_set, svc_set, svc_after_eoi;
  logic [PRIO_W-1:0] tp;
  logic [VEC_W-1:0]  spv;

  ack_cfg_regs #(.TP_W(PRIO_W), .VEC_W(VEC_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .tp_we  (reg_wr && sel == SEL_TASK),
    .spv_we (reg_wr && sel == SEL_SPUR),
    .wdata  (reg_wdata),
    .tp     (tp),
    .spv    (spv)
  );

  // Best pending, best in service, and best in service after one retire.
  logic              p_any, s_any, e_any;
  logic [IW-1:0]     p_idx, s_idx, e_idx;
  logic [PRIO_W-1:0] p_top, s_top, e_top;

  ack_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick_pend (
    .members(pend_set), .prio(src_prio), .any(p_any), .idx(p_idx), .top(p_top));
  ack_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick_svc (
    .members(svc_set), .prio(src_prio), .any(s_any), .idx(s_idx), .top(s_top));

  assign svc_after_eoi = svc_set & ~(N_SRC'(1) << s_idx);

  ack_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick_eoi (
    .members(svc_after_eoi), .prio(src_prio), .any(e_any), .idx(e_idx), .top(e_top));

  // Delivery path
  logic              reg_busy, dlv_fire, dlv_take, dlv_hidden;
  logic [PRIO_W-1:0] d_prio;

  assign reg_busy   = reg_rd || reg_wr;
  assign dlv_ready  = !reg_busy;
  assign dlv_fire   = dlv_valid && dlv_ready;
  assign d_prio     = src_prio[dlv_idx];
  assign dlv_take   = dlv_fire && (d_prio > tp) && !pend_set[dlv_idx];
  assign dlv_hidden = (p_any && d_prio < p_top) || (s_any && d_prio < s_top);

  // Acknowledge and end-of-interrupt
  logic ack_fire, ack_ok, eoi_fire, eoi_raise;

  assign lk_idx    = p_idx;
  assign ack_fire  = reg_rd && sel == SEL_ACK;
  assign ack_ok    = p_any && lk_active && (p_top > tp);
  assign eoi_fire  = reg_wr && sel == SEL_EOI;
  assign eoi_raise = p_any && (!e_any || p_top > e_top);

  assign act_set      = dlv_take;
  assign act_set_idx  = dlv_idx;
  assign act_clr      = ack_fire && p_any && (!ack_ok || !lk_level);
  assign act_clr_pend = ack_fire && p_any && !lk_level;
  assign act_clr_idx  = p_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_set <= '0;
      svc_set  <= '0;
      irq_out  <= 1'b0;
    end else begin
      if (dlv_take)          pend_set[dlv_idx] <= 1'b1;
      if (ack_fire && p_any) pend_set[p_idx]   <= 1'b0;
      if (ack_fire && ack_ok) svc_set[p_idx]   <= 1'b1;
      if (eoi_fire && s_any) svc_set[s_idx]    <= 1'b0;
      if (ack_fire)                      irq_out <= 1'b0;
      else if (eoi_fire && eoi_raise)    irq_out <= 1'b1;
      else if (dlv_take && !dlv_hidden)  irq_out <= 1'b1;
    end
  end

  // Register read data, one cycle after the strobe
  logic [VEC_W-1:0] rd_next;
  always_comb begin
    unique case (sel)
      SEL_TASK: rd_next = VEC_W'(tp);
      SEL_ACK:  rd_next = ack_ok ? lk_vec : spv;
      SEL_EOI:  rd_next = '0;
      default:  rd_next = spv;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_next;
    end
  end

  // Assertions
  a_r6_ack_lowers_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd1) |=> !irq_out);
  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  a_r11_eoi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd2) |=> rd_data == '0);
  a_r12_no_take_on_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> !act_set);
  a_r2_take_above_task: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |-> src_prio[act_set_idx] > tp);
  a_r9_pend_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    act_clr_pend |-> act_clr);
  a_r5_pick_is_member: assert property (@(posedge clk) disable iff (!rst_n)
    p_any |-> pend_set[p_idx]);
  a_r3_take_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |=> pend_set[$past(act_set_idx)]);
endmodule

// File: tb/test_prio_ack_engine.sv
`timescale 1ns/1ps
module test_prio_ack_engine;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic dlv_valid = 1'b0, dlv_ready;
  logic [IW-1:0] dlv_idx = '0;
  logic [N-1:0][3:0] src_prio = '0;
  logic [IW-1:0] lk_idx;
  logic [7:0] lk_vec;
  logic lk_active, lk_level;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic act_set, act_clr, act_clr_pend;
  logic [IW-1:0] act_set_idx, act_clr_idx;
  logic irq_out;

  // Source storage model owned by the bench
  logic [N-1:0] act_m;
  logic [N-1:0] level_m = '1;
  logic [N-1:0] kill = '0;
  assign lk_vec    = 8'h40 + 8'(lk_idx);
  assign lk_active = act_m[lk_idx];
  assign lk_level  = level_m[lk_idx];

  always @(posedge clk) begin
    if (!rst_n) act_m <= '0;
    else begin
      logic [N-1:0] nx;
      nx = act_m;
      if (act_set) nx[act_set_idx] = 1'b1;
      if (act_clr) nx[act_clr_idx] = 1'b0;
      act_m <= nx & ~kill;
    end
  end

  prio_ack_engine #(.N_SRC(N), .PRIO_W(4), .VEC_W(8)) i_prio_ack_engine (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_idx(dlv_idx), .src_prio(src_prio), .lk_idx(lk_idx), .lk_vec(lk_vec),
    .lk_active(lk_active), .lk_level(lk_level), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .act_set(act_set), .act_set_idx(act_set_idx), .act_clr(act_clr),
    .act_clr_pend(act_clr_pend), .act_clr_idx(act_clr_idx), .irq_out(irq_out));

  int n_cmp = 0;
  int n_bad = 0;
  logic cap_clr, cap_pend;
  logic [IW-1:0] cap_idx;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dlv_valid = 0; reg_rd = 0; reg_wr = 0; kill = '0;
    level_m = '1; src_prio = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic deliver(input int idx, output logic took);
    @(negedge clk);
    dlv_valid = 1'b1; dlv_idx = IW'(idx);
    #1 took = act_set;
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic reg_write(input int sel, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int sel, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 2'(sel);
    #1 cap_clr = act_clr; cap_pend = act_clr_pend; cap_idx = act_clr_idx;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R11 rd_valid", int'(rd_valid), 1);
    d = int'(rd_data);
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    chk("R1 irq after reset", int'(irq_out), 0);
    reg_read(0, d); chk("R1 task priority", d, 15);
    reg_read(3, d); chk("R1 spurious vector", d, 8'hFF);
    reg_read(1, d); chk("R6 empty acknowledge", d, 8'hFF);
  endtask

  task automatic t_filter();
    logic t;
    do_reset();
    src_prio[1] = 4'd5;
    deliver(1, t); chk("R2 below reset task", int'(t), 0);
    chk("R2 irq stays low", int'(irq_out), 0);
    reg_write(0, 5);
    deliver(1, t); chk("R2 equal to task", int'(t), 0);
    reg_write(0, 4);
    deliver(1, t); chk("R4 accepted", int'(t), 1);
    chk("R4 irq raised", int'(irq_out), 1);
    deliver(1, t); chk("R3 repeat dropped", int'(t), 0);
  endtask

  task automatic t_backpressure();
    int d;
    do_reset();
    src_prio[2] = 4'd6;
    reg_write(0, 2);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 2'd0; dlv_valid = 1'b1; dlv_idx = 3'd2;
    #1 chk("R12 ready low", int'(dlv_ready), 0);
    chk("R12 no take", int'(act_set), 0);
    @(negedge clk);
    reg_rd = 1'b0; dlv_valid = 1'b0;
    reg_read(1, d); chk("R12 nothing pending", d, 8'hFF);
  endtask

  task automatic t_select();
    int d; logic t;
    do_reset();
    reg_write(0, 2);
    src_prio[1] = 4'd5; src_prio[2] = 4'd7; src_prio[3] = 4'd7; src_prio[0] = 4'd4;
    deliver(3, t); deliver(2, t); deliver(1, t);
    reg_read(1, d); chk("R5 tie lowest index", d, 8'h42);
    chk("R6 ack lowers irq", int'(irq_out), 0);
    deliver(0, t); chk("R4 hidden accepted", int'(t), 1);
    chk("R4 hidden by pending", int'(irq_out), 0);
    reg_read(1, d); chk("R5 next best", d, 8'h43);
    reg_read(1, d); chk("R5 third", d, 8'h41);
    reg_read(1, d); chk("R5 lowest", d, 8'h40);
    reg_read(1, d); chk("R6 drained", d, 8'hFF);
  endtask

  task automatic t_eoi();
    int d; logic t;
    do_reset();
    reg_write(0, 2);
    src_prio[6] = 4'd6; src_prio[4] = 4'd3; src_prio[5] = 4'd7;
    deliver(6, t); chk("R4 irq for 6", int'(irq_out), 1);
    reg_read(1, d); chk("R8 vector 6", d, 8'h46);
    deliver(4, t); chk("R4 hidden by service", int'(irq_out), 0);
    deliver(5, t); chk("R4 above service", int'(irq_out), 1);
    reg_read(1, d); chk("R8 vector 5", d, 8'h45);
    reg_write(2, 0); chk("R10 still masked", int'(irq_out), 0);
    reg_write(2, 0); chk("R10 reassert", int'(irq_out), 1);
    reg_read(1, d); chk("R8 vector 4", d, 8'h44);
    reg_write(2, 0); chk("R10 nothing pending", int'(irq_out), 0);
    reg_read(2, d); chk("R11 eoi reads zero", d, 0);
  endtask

  task automatic t_stale();
    int d; logic t;
    do_reset();
    reg_write(0, 2);
    src_prio[3] = 4'd5; level_m[3] = 1'b0;
    deliver(3, t);
    reg_read(1, d); chk("R8 edge vector", d, 8'h43);
    chk("R9 clear", int'(cap_clr), 1);
    chk("R9 clear pending", int'(cap_pend), 1);
    chk("R9 clear index", int'(cap_idx), 3);
    src_prio[7] = 4'd4;
    deliver(7, t);
    @(negedge clk); kill[7] = 1'b1;
    @(negedge clk); kill[7] = 1'b0;
    reg_read(1, d); chk("R7 inactive spurious", d, 8'hFF);
    chk("R7 clear", int'(cap_clr), 1);
    chk("R7 no pend clear", int'(cap_pend), 0);
    chk("R7 clear index", int'(cap_idx), 7);
    reg_read(1, d); chk("R7 removed", d, 8'hFF);
    src_prio[0] = 4'd4;
    deliver(0, t);
    reg_write(0, 6);
    reg_read(1, d); chk("R7 task raised", d, 8'hFF);
    reg_write(2, 0); chk("R10 eoi drains service", int'(irq_out), 0);
    reg_write(2, 0); reg_write(0, 2);
    reg_read(1, d); chk("R7 not kept", d, 8'hFF);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_filter();
    t_backpressure();
    t_select();
    t_eoi();
    t_stale();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule